// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits beside a synchronous DRAM command path and turns one column-access command into the column address of every data beat in the burst. Its settings come from a mode word. That word holds a burst length code, an ordering bit and a write single-beat bit. A one-cycle start pulse gives it a starting column and a read/write flag. The block then presents one column per advancing cycle. It does this until the burst is used up, a terminate pulse arrives, or a fresh start replaces it.

Addresses leave as a plain stream: `col_valid` marks a beat and `col_last` marks the final beat of a finite burst. There is no ready input. A stall is requested with `hold`, which acts as the stream's back-pressure. While `hold` is high, nothing moves: the beat on the outputs stays presented, and start and terminate pulses in that cycle are discarded. The mode word and flag are captured at an accepted start, so they may change while a burst runs. Bank selection and data handling belong elsewhere.

Top module: `sdr_burst_colgen`

## Requirements
- R1: After reset `col_valid`, `col_last` and `cfg_err` are all 0.
- R2: A start accepted at a clock edge (`hold` low) makes the next cycle show `col_valid`=1 with `col` equal to the start column. The mode word and read/write flag are captured at that edge.
- R3: Length code `mode_word[2:0]` values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats on consecutive non-held cycles. `col_valid` is 0 after the final beat.
- R4: With ordering bit `mode_word[3]`=0 (wrapping), beat n shows the start column with its low log2(length) bits replaced by (start + n) modulo length. The upper bits are unchanged.
- R5: With `mode_word[3]`=1 (interleaved), beat n shows the start column XOR n.
- R6: Code 7 with `mode_word[3]`=0 is full-page: beat n shows (start + n) mod 256 across all columns. The burst runs until a terminate or a new start, and `col_last` is never raised.
- R7: With `mode_word[9]`=1, a write burst (`is_write`=1) has exactly one beat whatever the code. A read still uses the coded length.
- R8: `col_last` is 1 exactly on the final beat of a finite burst.
- R9: A terminate seen with `hold` low ends the burst. The beat shown in that cycle is the last one presented.
- R10: A start during a running burst discards it. The next cycle shows beat 0 of the new burst.
- R11: While `hold` is 1, `col`, `col_valid` and `col_last` keep their values into the next cycle, and start and terminate are ignored.
- R12: The reserved codes are 4, 5 and 6, and also 7 with interleaving. An accepted start with a reserved code runs a 1-beat burst and sets `cfg_err`. `cfg_err` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_word | input | 10 | [2:0] length code, [3] interleave, [9] write single-beat |
| start | input | 1 | Begin a burst |
| start_col | input | COL_W | First column of the burst |
| is_write | input | 1 | Burst is a write |
| term | input | 1 | End the running burst |
| hold | input | 1 | Freeze the block this cycle (stall) |
| col | output | COL_W | Column of the present beat |
| col_valid | output | 1 | A beat is presented |
| col_last | output | 1 | Final beat of a finite burst |
| cfg_err | output | 1 | Sticky reserved-code flag |

## Verification
The bench sweeps every start column with every finite length, both orderings, both directions and both settings of the single-beat bit. Two kinds of fault show up here: a wrap that carries into the upper column bits, and an interleave that adds instead of XORing. A design that drops the write override produces four or eight beats where one is expected. Full-page mode is run past the column 255 boundary. A design that stops at the coded length, or raises `col_last`, would miss this case. Stall, terminate, restart and reserved-code scenarios catch a block that keeps counting under `hold`, honours a start during a stall, shows one beat too many after terminate, or lets `cfg_err` drop.

// File: rtl/sdr_colgen_pkg.sv
package sdr_colgen_pkg;
  localparam int MODE_W   = 10;
  localparam int LEN_LSB  = 0;
  localparam int LEN_W    = 3;
  localparam int ILV_BIT  = 3;
  localparam int WSB_BIT  = 9;
  localparam int LG_W     = 2;
  localparam logic [LEN_W-1:0] CODE_PAGE = 3'd7;

  typedef struct packed {
    logic [LG_W-1:0] lg;
    logic            full;
    logic            bad;
  } span_t;
endpackage

// File: rtl/colgen_span_decode.sv
module colgen_span_decode
  import sdr_colgen_pkg::*;
(
  input  logic [LEN_W-1:0] len_code,
  input  logic             ilv,
  input  logic             wsb,
  input  logic             is_write,
  output span_t            span
);
  always_comb begin
    span = '0;
    if (len_code <= 3'd3) begin
      span.lg = len_code[LG_W-1:0];
    end else if (len_code == CODE_PAGE && !ilv) begin
      span.full = 1'b1;
    end else begin
      span.bad = 1'b1;
    end
    if (wsb && is_write) begin
      span.lg   = '0;
      span.full = 1'b0;
    end
  end
endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             load,
  input  logic             kill,
  input  logic [LG_W-1:0]  lg_in,
  input  logic             full_in,
  output logic [COL_W-1:0] beat,
  output logic [LG_W-1:0]  lg_q,
  output logic             full_q,
  output logic             active,
  output logic             last
);
  logic [COL_W-1:0] final_beat;

  always_comb begin
    final_beat = COL_W'((1 << lg_q) - 1);
    last       = active && !full_q && (beat == final_beat);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
      lg_q   <= '0;
      full_q <= 1'b0;
    end else if (!hold) begin
      if (load) begin
        active <= 1'b1;
        beat   <= '0;
        lg_q   <= lg_in;
        full_q <= full_in;
      end else if (active) begin
        if (kill || last) begin
          active <= 1'b0;
        end else begin
          beat <= beat + 1'b1;
        end
      end
    end
  end

  assert_beat_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !hold && !load && !kill && !last) |=> (active && beat == $past(beat) + 1'b1));
endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [LG_W-1:0]  lg,
  input  logic             ilv,
  input  logic             full,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] sum;

  always_comb begin
    wrap_mask = full ? '1 : COL_W'((1 << lg) - 1);
    sum       = base + beat;
  end

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    always_comb begin
      if (!wrap_mask[i])
        col[i] = base[i];
      else if (ilv)
        col[i] = base[i] ^ beat[i];
      else
        col[i] = sum[i];
    end
  end
endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              is_write,
  input  logic              term,
  input  logic              hold,
  output logic [COL_W-1:0]  col,
  output logic              col_valid,
  output logic              col_last,
  output logic              cfg_err
);
  span_t            span;
  logic [COL_W-1:0] base_q;
  logic             ilv_q;
  logic [COL_W-1:0] beat;
  logic [LG_W-1:0]  lg_q;
  logic             full_q;
  logic             accept;

  assign accept = start && !hold;

  colgen_span_decode u_dec (
    .len_code (mode_word[LEN_LSB +: LEN_W]),
    .ilv      (mode_word[ILV_BIT]),
    .wsb      (mode_word[WSB_BIT]),
    .is_write (is_write),
    .span     (span)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      ilv_q   <= 1'b0;
      cfg_err <= 1'b0;
    end else if (accept) begin
      base_q <= start_col;
      ilv_q  <= mode_word[ILV_BIT];
      if (span.bad) cfg_err <= 1'b1;
    end
  end

  colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold),
    .load    (start),
    .kill    (term),
    .lg_in   (span.lg),
    .full_in (span.full),
    .beat    (beat),
    .lg_q    (lg_q),
    .full_q  (full_q),
    .active  (col_valid),
    .last    (col_last)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .base (base_q),
    .beat (beat),
    .lg   (lg_q),
    .ilv  (ilv_q),
    .full (full_q),
    .col  (col)
  );

  assert_start_shows_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (col_valid && col == $past(start_col)));
  assert_last_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !hold && !start) |=> !col_valid);
  assert_term_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !hold && !start) |=> !col_valid);
  assert_hold_freezes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(col) && $stable(col_valid) && $stable(col_last)));
  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

// File: tb/sdr_burst_colgen_test.sv
module sdr_burst_colgen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] mode_word = '0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic       is_write = 1'b0;
  logic       term = 1'b0;
  logic       hold = 1'b0;
  logic [7:0] col;
  logic       col_valid, col_last, cfg_err;
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdr_burst_colgen uut (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .start(start),
    .start_col(start_col), .is_write(is_write), .term(term), .hold(hold),
    .col(col), .col_valid(col_valid), .col_last(col_last), .cfg_err(cfg_err)
  );

  task automatic check_eq(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_col(int base, int n, int lg, int ilv, int full);
    int m;
    if (full) return (base + n) & 255;
    m = (1 << lg) - 1;
    if (ilv) return base ^ n;
    return (base & ~m & 255) | ((base + n) & m);
  endfunction

  task automatic launch(int code, int ilv, int wsb, int wr, int c);
    mode_word = 10'((wsb << 9) | (ilv << 3) | code);
    start     = 1'b1;
    start_col = 8'(c);
    is_write  = wr[0];
  endtask

  // Full burst with no interruption, checked beat by beat, then idle.
  task automatic run_burst(int code, int ilv, int wsb, int wr, int c);
    int lg, len;
    @(negedge clk);
    launch(code, ilv, wsb, wr, c);
    @(negedge clk);
    start = 1'b0;
    lg  = (wr && wsb) ? 0 : code;
    len = 1 << lg;
    for (int n = 0; n < len; n++) begin
      check_eq("R3 valid in burst", int'(col_valid), 1);
      if (wr && wsb) check_eq("R7 write single beat col", int'(col), c);
      else if (ilv)  check_eq("R5 interleaved col", int'(col), exp_col(c, n, lg, 1, 0));
      else           check_eq("R4 wrapping col", int'(col), exp_col(c, n, lg, 0, 0));
      check_eq("R8 last flag", int'(col_last), int'(n == len - 1));
      @(negedge clk);
    end
    check_eq("R3 idle after burst", int'(col_valid), 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 reset valid", int'(col_valid), 0);
    check_eq("R1 reset last", int'(col_last), 0);
    check_eq("R1 reset err", int'(cfg_err), 0);

    // Exhaustive sweep of finite lengths.
    for (int code = 0; code < 4; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int wsb = 0; wsb < 2; wsb++)
          for (int wr = 0; wr < 2; wr++)
            for (int c = 0; c < 256; c++)
              run_burst(code, ilv, wsb, wr, c);
    check_eq("R12 no error for legal codes", int'(cfg_err), 0);

    // R2: mode captured at start, changed mid-burst
    @(negedge clk);
    launch(2, 0, 0, 0, 8'h3A);
    @(negedge clk);
    start = 1'b0;
    mode_word = 10'h00B;
    for (int n = 0; n < 4; n++) begin
      check_eq("R2 captured mode col", int'(col), exp_col(8'h3A, n, 2, 0, 0));
      @(negedge clk);
    end
    check_eq("R2 captured length", int'(col_valid), 0);

    // R6: full page crossing column 255
    @(negedge clk);
    launch(7, 0, 0, 0, 8'hFE);
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 300; n++) begin
      check_eq("R6 page col", int'(col), exp_col(8'hFE, n, 0, 0, 1));
      check_eq("R6 page no last", int'(col_last), 0);
      if (n == 299) term = 1'b1;
      @(negedge clk);
    end
    term = 1'b0;
    check_eq("R6 page ended by terminate", int'(col_valid), 0);

    // R9: terminate an 8-beat burst on beat 2
    @(negedge clk);
    launch(3, 0, 0, 0, 8'h40);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_eq("R9 beat shown with terminate", int'(col), 8'h42);
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    check_eq("R9 stopped after terminate", int'(col_valid), 0);

    // R10: restart on beat 3 of an 8-beat burst
    @(negedge clk);
    launch(3, 0, 0, 0, 8'h10);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R10 old burst beat 3", int'(col), 8'h13);
    launch(2, 1, 0, 0, 8'h25);
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 4; n++) begin
      check_eq("R10 new burst col", int'(col), 8'h25 ^ n);
      check_eq("R10 new burst last", int'(col_last), int'(n == 3));
      @(negedge clk);
    end
    check_eq("R10 new burst ends", int'(col_valid), 0);

    // R11: hold on beat 1, with start and terminate ignored
    @(negedge clk);
    launch(2, 0, 0, 0, 8'h07);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    hold = 1'b1; term = 1'b1; start = 1'b1; start_col = 8'hC0;
    for (int k = 0; k < 3; k++) begin
      check_eq("R11 held col", int'(col), 8'h04);
      check_eq("R11 held valid", int'(col_valid), 1);
      @(negedge clk);
    end
    hold = 1'b0; term = 1'b0; start = 1'b0;
    check_eq("R11 still beat 1", int'(col), 8'h04);
    @(negedge clk);
    check_eq("R11 resumes beat 2", int'(col), 8'h05);
    @(negedge clk);
    check_eq("R11 resumes beat 3", int'(col), 8'h06);
    check_eq("R11 last after hold", int'(col_last), 1);
    @(negedge clk);
    check_eq("R11 ends after hold", int'(col_valid), 0);

    // R12: reserved codes
    check_eq("R12 err clear before reserved", int'(cfg_err), 0);
    @(negedge clk);
    launch(5, 0, 0, 0, 8'h33);
    @(negedge clk);
    start = 1'b0;
    check_eq("R12 reserved col", int'(col), 8'h33);
    check_eq("R12 reserved one beat", int'(col_last), 1);
    check_eq("R12 err raised", int'(cfg_err), 1);
    @(negedge clk);
    check_eq("R12 reserved ends", int'(col_valid), 0);
    run_burst(1, 0, 0, 0, 8'h81);
    check_eq("R12 err sticky", int'(cfg_err), 1);
    @(negedge clk);
    launch(7, 1, 0, 0, 8'h90);
    @(negedge clk);
    start = 1'b0;
    check_eq("R12 interleaved page one beat", int'(col_last), 1);
    @(negedge clk);
    check_eq("R12 interleaved page ends", int'(col_valid), 0);

    // R1: reset clears the sticky flag
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 err after reset", int'(cfg_err), 0);
    check_eq("R1 valid after reset", int'(col_valid), 0);

    done = 1;
    finish_run();
  end
endmodule